// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic array. A bank of product terms is formed from the input vector: each term is the AND of the true and complemented literals that its fuse mask selects. A fixed OR gathers all the terms of the cell into one sum. Two configuration bits then shape what leaves the cell. One bit chooses between the raw sum (combinatorial) and the value held in a D flip-flop that captures the sum on each rising clock edge (registered). The other bit chooses the polarity at the pin.

The flip-flop has four controls. A global clear term acts asynchronously. A global preset term acts only at a clock edge. A test preload strobe forces any state, including states the logic could never reach. A dedicated product term, with its own fuse mask, drives the pin's output enable. The cell also returns a feedback value to the routing fabric around it: the flip-flop state in registered mode, and the sum in combinatorial mode. Signals fed back from this or other cells reach the AND plane again as ordinary bits of the input vector, so the cell itself holds no combinational loop.

Top module: `sop_macrocell`

## Requirements
- R1: For term t, fuse bit `and_fuse[t*2*N_IN + 2*i]` selects input i in true form and bit `t*2*N_IN + 2*i + 1` selects it complemented. The term is the AND of its selected literals. A term with no selected literal is false, and so is a term that selects both forms of one input.
- R2: The sum is the OR of all N_TERMS product terms (1 to 16). In combinatorial mode (`cfg_registered` = 0) the pin value follows the sum in the same cycle, before polarity is applied.
- R3: While `clr_async` is 1, the flip-flop reads 0 at once, with no clock edge needed. This overrides preset and preload at any edge it covers.
- R4: `preset_sync` = 1 sets the flip-flop to 1 at the next rising clock edge and not before.
- R5: With `cfg_active_high` = 1 the pin carries the selected value unchanged. With 0 it carries the inverse. Clear, preset and preload act on the flip-flop only, so the pin shows their effect through this polarity.
- R6: In registered mode (`cfg_registered` = 1) the pin value comes from the flip-flop. When no other control is active, the flip-flop captures the sum at each rising edge.
- R7: `preload_en` = 1 at a rising edge loads `preload_val` into the flip-flop, whatever the sum is. It takes precedence over preset, but not over clear.
- R8: `pin_oe` is the AND of the literals selected in `oe_fuse`, using the same bit layout as a product term in R1. An empty `oe_fuse` keeps the output enabled (1).
- R9: `fb_out` equals the flip-flop state in registered mode and the sum in combinatorial mode, whatever the polarity.
- R10: After clear the flip-flop is 0. In registered active-low mode this shows as 1 at the pin and 0 on `fb_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock of the cell flip-flop |
| clr_async | input | 1 | Global asynchronous clear term, also used as power-up clear |
| in_vec | input | N_IN | Input literals, including any routed feedback |
| and_fuse | input | N_TERMS*2*N_IN | AND-plane fuse mask for all product terms |
| oe_fuse | input | 2*N_IN | Fuse mask of the output-enable product term |
| cfg_registered | input | 1 | 1 selects the registered path, 0 the combinatorial one |
| cfg_active_high | input | 1 | 1 selects active-high output, 0 active-low |
| preset_sync | input | 1 | Global synchronous preset term |
| preload_en | input | 1 | Test strobe that loads the flip-flop |
| preload_val | input | 1 | Value loaded by the preload strobe |
| pin_data | output | 1 | Data driven toward the pin after polarity |
| pin_oe | output | 1 | Output enable; 0 means the pin is tri-stated |
| fb_out | output | 1 | Feedback value toward the routing fabric |

## Verification
The assertions check on every clock edge the relations that hold whatever the fuses are: what the flip-flop takes at an edge under preload, preset, or plain capture; that clear holds it at 0; and how `pin_data` and `fb_out` follow the flip-flop or the sum in each mode. Other behaviour only the bench scenarios can show. One part is the decoding of random fuse maps into the right sum and output enable, checked against a reference model in all four configuration modes. The other part is timing at the cell's edges: that clear acts between edges while preset waits for the edge, and that the empty and self-contradicting terms come out as specified.

// File: rtl/sop_pkg.sv
package sop_pkg;

    localparam int MAX_TERMS = 16;

    typedef struct packed {
        logic registered;
        logic active_high;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } cell_state_t;

    typedef struct packed {
        logic sel_val;
        logic pin_val;
        logic fb_val;
    } out_sel_t;

endpackage

// File: rtl/sop_pterm.sv
module sop_pterm #(
    parameter int   N_IN      = 10,
    parameter logic EMPTY_VAL = 1'b0,
    localparam int  LIT_W     = 2 * N_IN
) (
    input  logic [N_IN-1:0]  in_vec,
    input  logic [LIT_W-1:0] fuse,
    output logic             term
);

    logic [LIT_W-1:0] lits;

    // Literal pairs: even bit true form, odd bit complemented form
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = in_vec[i];
        assign lits[2*i+1] = ~in_vec[i];
    end

    always_comb begin
        if (fuse == '0) begin
            term = EMPTY_VAL;
        end else begin
            term = &(lits | ~fuse);
        end
    end

endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg
    import sop_pkg::*;
(
    input  logic clk,
    input  logic clr_async,
    input  logic preset_sync,
    input  logic preload_en,
    input  logic preload_val,
    input  logic sum,
    output logic q
);

    cell_state_t st_d;
    cell_state_t st_q;

    // Priority at an edge: preload, then preset, then captured sum
    always_comb begin
        st_d = st_q;
        if (preload_en) begin
            st_d.q = preload_val;
        end else if (preset_sync) begin
            st_d.q = 1'b1;
        end else begin
            st_d.q = sum;
        end
    end

    // Clear dominates everything and needs no edge
    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

endmodule

// File: rtl/sop_out_sel.sv
module sop_out_sel
    import sop_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      q,
    input  logic      sum,
    output logic      pin_val,
    output logic      fb_val
);

    out_sel_t sel_d;

    always_comb begin
        sel_d.sel_val = cfg.registered ? q : sum;
        sel_d.pin_val = cfg.active_high ? sel_d.sel_val : ~sel_d.sel_val;
        sel_d.fb_val  = sel_d.sel_val;
    end

    assign pin_val = sel_d.pin_val;
    assign fb_val  = sel_d.fb_val;

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int  N_IN    = 10,
    parameter int  N_TERMS = 16,
    localparam int LIT_W   = 2 * N_IN,
    localparam int FUSE_W  = N_TERMS * LIT_W
) (
    input  logic              clk,
    input  logic              clr_async,
    input  logic [N_IN-1:0]   in_vec,
    input  logic [FUSE_W-1:0] and_fuse,
    input  logic [LIT_W-1:0]  oe_fuse,
    input  logic              cfg_registered,
    input  logic              cfg_active_high,
    input  logic              preset_sync,
    input  logic              preload_en,
    input  logic              preload_val,
    output logic              pin_data,
    output logic              pin_oe,
    output logic              fb_out
);

    if (N_TERMS < 1 || N_TERMS > MAX_TERMS) begin : g_bad_terms
        $error("sop_macrocell: N_TERMS out of range");
    end

    logic [N_TERMS-1:0] terms;
    logic               sum;
    logic               reg_q;
    cell_cfg_t          cfg;

    assign cfg.registered  = cfg_registered;
    assign cfg.active_high = cfg_active_high;

    // AND plane: one product term per OR input
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        sop_pterm #(
            .N_IN      (N_IN),
            .EMPTY_VAL (1'b0)
        ) u_pterm (
            .in_vec (in_vec),
            .fuse   (and_fuse[t*LIT_W +: LIT_W]),
            .term   (terms[t])
        );
    end

    // Fixed OR plane
    assign sum = |terms;

    // Output-enable term: empty mask means always driven
    sop_pterm #(
        .N_IN      (N_IN),
        .EMPTY_VAL (1'b1)
    ) u_oe_term (
        .in_vec (in_vec),
        .fuse   (oe_fuse),
        .term   (pin_oe)
    );

    sop_cell_reg u_reg (
        .clk         (clk),
        .clr_async   (clr_async),
        .preset_sync (preset_sync),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .sum         (sum),
        .q           (reg_q)
    );

    sop_out_sel u_sel (
        .cfg     (cfg),
        .q       (reg_q),
        .sum     (sum),
        .pin_val (pin_data),
        .fb_val  (fb_out)
    );

endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk (
    input logic clk,
    input logic clr_async,
    input logic cfg_registered,
    input logic cfg_active_high,
    input logic preset_sync,
    input logic preload_en,
    input logic preload_val,
    input logic sum,
    input logic reg_q,
    input logic pin_data,
    input logic fb_out
);

    // R3: clear holds the flip-flop low (no disable: clear is the subject)
    p_clear_r3: assert property (@(posedge clk)
        clr_async |-> !reg_q);

    // R4: preset without preload gives 1 after the edge
    p_preset_r4: assert property (@(posedge clk) disable iff (clr_async)
        (preset_sync && !preload_en) |=> reg_q);

    // R7: preload loads the supplied value
    p_preload_r7: assert property (@(posedge clk) disable iff (clr_async)
        preload_en |=> (reg_q == $past(preload_val)));

    // R6: plain capture of the sum
    p_capture_r6: assert property (@(posedge clk) disable iff (clr_async)
        (!preload_en && !preset_sync) |=> (reg_q == $past(sum)));

    // R5: registered pin is the flip-flop through the polarity choice
    p_reg_pin_r5: assert property (@(posedge clk) disable iff (clr_async)
        cfg_registered |-> (pin_data == (cfg_active_high ? reg_q : !reg_q)));

    // R2: combinatorial pin follows the sum
    p_comb_pin_r2: assert property (@(posedge clk) disable iff (clr_async)
        !cfg_registered |-> (pin_data == (cfg_active_high ? sum : !sum)));

    // R9: feedback source by mode
    p_fb_reg_r9: assert property (@(posedge clk) disable iff (clr_async)
        cfg_registered |-> (fb_out == reg_q));

    p_fb_comb_r9: assert property (@(posedge clk) disable iff (clr_async)
        !cfg_registered |-> (fb_out == sum));

endmodule

bind sop_macrocell sop_macrocell_chk u_chk (
    .clk             (clk),
    .clr_async       (clr_async),
    .cfg_registered  (cfg_registered),
    .cfg_active_high (cfg_active_high),
    .preset_sync     (preset_sync),
    .preload_en      (preload_en),
    .preload_val     (preload_val),
    .sum             (sum),
    .reg_q           (reg_q),
    .pin_data        (pin_data),
    .fb_out          (fb_out)
);

// File: tb/sop_macrocell_bench.sv
module sop_macrocell_bench;

    localparam int N_IN    = 10;
    localparam int N_TERMS = 16;
    localparam int LW      = 2 * N_IN;
    localparam int FW      = N_TERMS * LW;

    logic          clk = 1'b0;
    logic          clr_async;
    logic [N_IN-1:0] in_vec;
    logic [FW-1:0] and_fuse;
    logic [LW-1:0] oe_fuse;
    logic          cfg_registered;
    logic          cfg_active_high;
    logic          preset_sync;
    logic          preload_en;
    logic          preload_val;
    logic          pin_data;
    logic          pin_oe;
    logic          fb_out;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic model_q  = 1'b0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    sop_macrocell #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_sop_macrocell (
        .clk             (clk),
        .clr_async       (clr_async),
        .in_vec          (in_vec),
        .and_fuse        (and_fuse),
        .oe_fuse         (oe_fuse),
        .cfg_registered  (cfg_registered),
        .cfg_active_high (cfg_active_high),
        .preset_sync     (preset_sync),
        .preload_en      (preload_en),
        .preload_val     (preload_val),
        .pin_data        (pin_data),
        .pin_oe          (pin_oe),
        .fb_out          (fb_out)
    );

    function automatic logic ref_term(logic [LW-1:0] f, logic [N_IN-1:0] x, logic empty_val);
        logic any = 1'b0;
        logic r   = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            if (f[2*i])   begin any = 1'b1; r = r & x[i];  end
            if (f[2*i+1]) begin any = 1'b1; r = r & ~x[i]; end
        end
        return any ? r : empty_val;
    endfunction

    function automatic logic ref_sum(logic [FW-1:0] f, logic [N_IN-1:0] x);
        logic s = 1'b0;
        for (int t = 0; t < N_TERMS; t++) s = s | ref_term(f[t*LW +: LW], x, 1'b0);
        return s;
    endfunction

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic v;
        v = cfg_registered ? model_q : ref_sum(and_fuse, in_vec);
        check(pin_data, cfg_active_high ? v : ~v, {tag, " R2/R5/R6 pin_data"});
        check(pin_oe, ref_term(oe_fuse, in_vec, 1'b1), {tag, " R8 pin_oe"});
        check(fb_out, v, {tag, " R9 fb_out"});
    endtask

    // advance to posedge, update model, return at next negedge
    task automatic tick();
        @(posedge clk);
        if (clr_async)        model_q = 1'b0;
        else if (preload_en)  model_q = preload_val;
        else if (preset_sync) model_q = 1'b1;
        else                  model_q = ref_sum(and_fuse, in_vec);
        @(negedge clk);
    endtask

    task automatic rand_fuses();
        for (int b = 0; b < FW; b++) and_fuse[b] = ($urandom % 8) == 0;
        for (int b = 0; b < LW; b++) oe_fuse[b]  = ($urandom % 10) == 0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        clr_async = 1'b1; in_vec = '0; and_fuse = '0; oe_fuse = '0;
        cfg_registered = 1'b1; cfg_active_high = 1'b0;
        preset_sync = 1'b0; preload_en = 1'b0; preload_val = 1'b0;
        repeat (2) @(negedge clk);
        #2;
        check(fb_out, 1'b0, "R10 reset fb_out");
        check(pin_data, 1'b1, "R10 reset active-low pin");
        check(pin_oe, 1'b1, "R8 empty oe mask");
        clr_async = 1'b0;
        @(negedge clk);

        // R1: empty and contradictory terms, single complement literal
        cfg_registered = 1'b0; cfg_active_high = 1'b1;
        #2 check(pin_data, 1'b0, "R1 empty terms false");
        and_fuse[1:0] = 2'b11;
        #2 check(pin_data, 1'b0, "R1 x and not x false");
        and_fuse = '0; and_fuse[LW + 7] = 1'b1; in_vec = '0;
        #2 check(pin_data, 1'b1, "R1 complement literal");
        cfg_active_high = 1'b0;
        #2 check(pin_data, 1'b0, "R5 active-low inversion");
        in_vec[3] = 1'b1;
        #2 check(pin_data, 1'b1, "R1 literal false");
        and_fuse = '0;
        @(negedge clk);

        // R4: preset waits for the edge
        cfg_registered = 1'b1; cfg_active_high = 1'b1; preset_sync = 1'b1;
        #2 check(fb_out, 1'b0, "R4 preset not immediate");
        tick();
        preset_sync = 1'b0;
        #2 check(fb_out, 1'b1, "R4 preset after edge");
        check(pin_data, 1'b1, "R5 preset through polarity");

        // R3: clear acts between edges and dominates at the edge
        clr_async = 1'b1; preset_sync = 1'b1; preload_en = 1'b1; preload_val = 1'b1;
        #2 check(fb_out, 1'b0, "R3 clear immediate");
        tick();
        #2 check(fb_out, 1'b0, "R3 clear beats preset and preload");
        clr_async = 1'b0; preset_sync = 1'b0; preload_en = 1'b0;
        @(negedge clk);
        model_q = 1'b0;

        // R7: preload of a state the sum cannot produce, then over preset
        cfg_active_high = 1'b0; preload_en = 1'b1; preload_val = 1'b1;
        tick();
        #2 check(fb_out, 1'b1, "R7 preload one");
        check(pin_data, 1'b0, "R7 preload seen active-low");
        preset_sync = 1'b1; preload_val = 1'b0;
        tick();
        #2 check(fb_out, 1'b0, "R7 preload over preset");
        preset_sync = 1'b0; preload_en = 1'b0;

        // Random fuse maps in all four modes
        for (int mode = 0; mode < 4; mode++) begin
            cfg_registered  = mode[1];
            cfg_active_high = mode[0];
            for (int blk = 0; blk < 4; blk++) begin
                rand_fuses();
                for (int c = 0; c < 60; c++) begin
                    in_vec      = N_IN'($urandom);
                    preset_sync = ($urandom % 10) == 0;
                    preload_en  = ($urandom % 12) == 0;
                    preload_val = 1'($urandom);
                    clr_async   = ($urandom % 40) == 0;
                    if (clr_async) model_q = 1'b0;
                    #2 check_all("random R6");
                    tick();
                end
            end
        end
        clr_async = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule